// File: doc/BRIEF.md
# Burst Beat Address Sequencer

This block produces the address of every beat of one memory-mapped burst. A load strobe captures a start address, a length field, a size field and a burst kind. From the next cycle the block presents the address of the current beat, together with a flag that marks the final beat. Each accepted data beat is signalled on the step input, which is the channel's VALID and READY both high at the rising edge. The block then moves on to the next beat address.

Three address rules are supported. A fixed burst repeats one address. An incrementing burst walks upward by the beat size. A wrapping burst walks upward inside an aligned window and folds back to the window's base. A reserved kind, or a wrapping burst with an unsupported beat count, raises an error flag for that burst. The block does not correct either case. It is meant to sit behind the address-channel handshake of a memory-mapped target or initiator and to drive the per-beat address of its data path.

Top module: `burst_addr_gen`

## Requirements
- R1: While and after reset, and before any load, `busy_o`, `last_o` and `err_o` are 0.
- R2: In the cycle after `load_i` is high at a clock edge, `busy_o` is 1 and `addr_o` equals the captured start address, even if that address is unaligned.
- R3: A burst holds `len_i`+1 beats, from 1 up to 256. `last_o` is 1 exactly while the final beat is presented. After a step on the final beat, `busy_o` is 0 in the next cycle.
- R4: The beat moves on only at an edge where `step_i` is 1 while `busy_o` is 1. With `step_i` low, `addr_o` and `last_o` hold. A step while idle has no effect: `busy_o` stays 0.
- R5: Kind code 2'b00 (fixed) presents the start address for every beat.
- R6: Kind code 2'b01 (incrementing) computes each later beat as the previous address aligned down to 2^`size_i` bytes, plus 2^`size_i`. Only the first beat can be unaligned.
- R7: Kind code 2'b10 (wrapping) uses a window of (`len_i`+1)·2^`size_i` bytes. The window's base is the start address aligned down to the window size. Beat i (i≥1) is base + ((start aligned to the size − base + i·2^`size_i`) mod window).
- R8: A wrapping burst is legal only with 2, 4, 8 or 16 beats. With any other count, `err_o` is 1 for the whole burst and the addresses follow the R6 rule.
- R9: Kind code 2'b11 is reserved. `err_o` is 1 for the whole burst and the address stays at the start address.
- R10: A load during an active burst takes priority over a step in the same cycle. It restarts the block with the new fields, and `err_o` is recomputed from them.
- R11: The beat size is 2^`size_i` bytes for every `size_i` value from 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Capture a new burst description |
| start_addr_i | input | ADDR_W | Address of the first beat |
| len_i | input | LEN_W | Beat count minus one |
| size_i | input | SIZE_W | Log2 of bytes per beat |
| kind_i | input | 2 | Burst kind: 00 fixed, 01 incrementing, 10 wrapping, 11 reserved |
| step_i | input | 1 | Beat accepted (VALID and READY both high) |
| addr_o | output | ADDR_W | Address of the current beat |
| last_o | output | 1 | Current beat is the final one |
| busy_o | output | 1 | A burst is in progress |
| err_o | output | 1 | Current burst has a reserved kind or an illegal wrap length |

## Verification
The bench sweeps every kind code against every size value and a set of lengths. The lengths are 1, 2, 3, 4, 8, 16, 17 and 256 beats, and every address is compared with a closed-form model. The legal wrap counts beside their non-power-of-two and oversized neighbours separate true wrapping from fallback incrementing. Start addresses are varied and often unaligned, which separates the align-then-add rule from a plain adder. Bursts alternate between back-to-back steps and stalled steps, which shows that the beat only advances on a step. Separate cases cover steps while idle and a load that cuts into a running burst.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  typedef enum logic [1:0] {
    BK_FIXED = 2'b00,
    BK_INCR  = 2'b01,
    BK_WRAP  = 2'b10,
    BK_RSVD  = 2'b11
  } burst_kind_e;

endpackage

// File: rtl/bag_decode.sv
module bag_decode
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int LEN_W         = 8,
  parameter int SIZE_W        = 3,
  parameter int WRAP_MAX_LOG2 = 4
) (
  input  logic [1:0]        kind_raw_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [SIZE_W-1:0] size_i,
  output burst_kind_e       mode_o,
  output logic [ADDR_W-1:0] size_mask_o,
  output logic [ADDR_W-1:0] win_mask_o,
  output logic              err_o
);

  localparam int BEAT_W = LEN_W + 1;

  logic [BEAT_W-1:0] beats;
  logic              wrap_legal;
  burst_kind_e       kind;

  assign kind  = burst_kind_e'(kind_raw_i);
  assign beats = {1'b0, len_i} + BEAT_W'(1);

  // wrap length legal when the beat count is a power of two from 2 upward
  always_comb begin
    wrap_legal = 1'b0;
    for (int k = 1; k <= WRAP_MAX_LOG2; k++) begin
      if (beats == BEAT_W'(1 << k)) wrap_legal = 1'b1;
    end
  end

  assign size_mask_o = (ADDR_W'(1) << size_i) - ADDR_W'(1);
  assign win_mask_o  = (ADDR_W'(beats) << size_i) - ADDR_W'(1);

  always_comb begin
    mode_o = BK_FIXED;
    err_o  = 1'b0;
    unique case (kind)
      BK_FIXED: mode_o = BK_FIXED;
      BK_INCR:  mode_o = BK_INCR;
      BK_WRAP: begin
        mode_o = wrap_legal ? BK_WRAP : BK_INCR;
        err_o  = !wrap_legal;
      end
      default: begin
        mode_o = BK_FIXED;
        err_o  = 1'b1;
      end
    endcase
  end

  // R8: a legal wrap always has a window covering at least the beat size
  always_comb begin
    if (mode_o == BK_WRAP)
      a_r8_window_covers_size: assert ((win_mask_o & size_mask_o) == size_mask_o);
  end

endmodule

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             step_i,
  output logic             busy_o,
  output logic             last_o,
  output logic             adv_o
);

  logic [LEN_W-1:0] left_q, left_d;
  logic             busy_q, busy_d;
  logic             cnt_en;

  assign adv_o  = step_i && busy_q && !load_i;
  assign cnt_en = load_i || adv_o;

  always_comb begin
    left_d = left_q;
    busy_d = busy_q;
    if (load_i) begin
      left_d = len_i;
      busy_d = 1'b1;
    end else if (adv_o) begin
      if (left_q == '0) busy_d = 1'b0;
      else              left_d = left_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (cnt_en) begin
      left_q <= left_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;
  assign last_o = busy_q && (left_q == '0);

  a_r3_last_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> busy_o);
  a_r3_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && step_i && !load_i) |=> !busy_o);
  a_r4_idle_step_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !load_i) |=> !busy_o);
  a_r4_hold_last: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !step_i && !load_i) |=> ($stable(last_o) && busy_o));

endmodule

// File: rtl/bag_addr_step.sv
module bag_addr_step
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_i,
  input  burst_kind_e       mode_i,
  input  logic [ADDR_W-1:0] size_mask_i,
  input  logic [ADDR_W-1:0] win_mask_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] cur_q, cur_d;
  logic [ADDR_W-1:0] smask_q, wmask_q;
  burst_kind_e       mode_q;
  logic [ADDR_W-1:0] aligned, bumped;
  logic              cfg_en, addr_en;

  assign aligned = cur_q & ~smask_q;
  assign bumped  = aligned + smask_q + ADDR_W'(1);
  assign cfg_en  = load_i;
  assign addr_en = load_i || adv_i;

  always_comb begin
    cur_d = cur_q;
    if (load_i) begin
      cur_d = start_i;
    end else if (adv_i) begin
      unique case (mode_q)
        BK_INCR: cur_d = bumped;
        BK_WRAP: cur_d = (cur_q & ~wmask_q) | (bumped & wmask_q);
        default: cur_d = cur_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= BK_FIXED;
      smask_q <= '0;
      wmask_q <= '0;
    end else if (cfg_en) begin
      mode_q  <= mode_i;
      smask_q <= size_mask_i;
      wmask_q <= win_mask_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else if (addr_en) cur_q <= cur_d;
  end

  assign addr_o = cur_q;

  a_r5_fixed_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == BK_FIXED && !load_i) |=> $stable(addr_o));
  a_r6_incr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == BK_INCR && adv_i && !load_i) |=> ((addr_o & smask_q) == '0));
  a_r7_wrap_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == BK_WRAP && adv_i && !load_i) |=>
      ((addr_o & ~wmask_q) == ($past(addr_o) & ~wmask_q)));
  a_r4_no_step_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !load_i) |=> $stable(addr_o));

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int LEN_W         = 8,
  parameter int SIZE_W        = 3,
  parameter int WRAP_MAX_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [1:0]        kind_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o,
  output logic              busy_o,
  output logic              err_o
);

  burst_kind_e       mode;
  logic [ADDR_W-1:0] size_mask, win_mask;
  logic              dec_err, adv;
  logic              err_q, err_d;

  bag_decode #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .WRAP_MAX_LOG2(WRAP_MAX_LOG2)
  ) u_decode (
    .kind_raw_i (kind_i),
    .len_i      (len_i),
    .size_i     (size_i),
    .mode_o     (mode),
    .size_mask_o(size_mask),
    .win_mask_o (win_mask),
    .err_o      (dec_err)
  );

  bag_beat_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(load_i),
    .len_i (len_i),
    .step_i(step_i),
    .busy_o(busy_o),
    .last_o(last_o),
    .adv_o (adv)
  );

  bag_addr_step #(.ADDR_W(ADDR_W)) u_step (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .start_i    (start_addr_i),
    .mode_i     (mode),
    .size_mask_i(size_mask),
    .win_mask_i (win_mask),
    .adv_i      (adv),
    .addr_o     (addr_o)
  );

  assign err_d = load_i ? dec_err : err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err_o = err_q && busy_o;

  a_r2_load_presents_start: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (busy_o && addr_o == $past(start_addr_i)));
  a_r9_reserved_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && kind_i == 2'b11) |=> err_o);
  a_r10_clean_kind_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && kind_i[1] == 1'b0) |=> !err_o);
  a_r1_err_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> busy_o);

endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

  logic        clk;
  logic        rst_n;
  logic        load_i;
  logic [31:0] start_addr_i;
  logic [7:0]  len_i;
  logic [2:0]  size_i;
  logic [1:0]  kind_i;
  logic        step_i;
  logic [31:0] addr_o;
  logic        last_o, busy_o, err_o;

  int checks;
  int errors;
  int cycles;

  burst_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_addr_i(start_addr_i),
    .len_i(len_i), .size_i(size_i), .kind_i(kind_i), .step_i(step_i),
    .addr_o(addr_o), .last_o(last_o), .busy_o(busy_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit wrap_ok(input logic [1:0] kind, input int len);
    return kind == 2'b10 && (len == 1 || len == 3 || len == 7 || len == 15);
  endfunction

  function automatic logic [31:0] model_addr(input logic [31:0] start, input logic [1:0] kind,
                                            input int size, input int len, input int i);
    logic [31:0] bytes, al, win, low;
    bytes = 32'd1 << size;
    if (kind == 2'b00 || kind == 2'b11 || i == 0) return start;
    al = start & ~(bytes - 1);
    if (wrap_ok(kind, len)) begin
      win = (len + 1) * bytes;
      low = start & ~(win - 1);
      return low + ((al - low + i * bytes) % win);
    end
    return al + i * bytes;
  endfunction

  task automatic load_burst(input logic [31:0] start, input logic [1:0] kind,
                            input int size, input int len, input bit with_step);
    load_i       = 1'b1;
    step_i       = with_step;
    start_addr_i = start;
    kind_i       = kind;
    size_i       = 3'(size);
    len_i        = 8'(len);
    @(negedge clk);
    load_i = 1'b0;
    step_i = 1'b0;
  endtask

  // walk a loaded burst from beat 'from' to the end, checking each beat
  task automatic walk(input logic [31:0] start, input logic [1:0] kind,
                      input int size, input int len, input bit stall, input int from);
    logic [31:0] exp;
    bit          exp_err;
    string       rq;
    exp_err = (kind == 2'b11) || (kind == 2'b10 && !wrap_ok(kind, len));
    rq = (kind == 2'b00) ? "R5" : (kind == 2'b01) ? "R6" :
         (kind == 2'b11) ? "R9" : (wrap_ok(kind, len) ? "R7" : "R8");
    for (int i = from; i <= len; i++) begin
      exp = model_addr(start, kind, size, len, i);
      chk(addr_o == exp, rq, "beat address (R11 size)", addr_o, exp);
      chk(last_o == (i == len), "R3", "last flag", 32'(last_o), 32'(i == len));
      chk(busy_o == 1'b1, "R2", "busy during burst", 32'(busy_o), 32'd1);
      chk(err_o == exp_err, (kind == 2'b11) ? "R9" : "R8", "error flag", 32'(err_o), 32'(exp_err));
      if (stall && (i % 2 == 1)) begin
        @(negedge clk);
        chk(addr_o == exp, "R4", "hold without step", addr_o, exp);
        chk(last_o == (i == len), "R4", "last holds", 32'(last_o), 32'(i == len));
      end
      step_i = 1'b1;
      @(negedge clk);
      step_i = 1'b0;
    end
    chk(busy_o == 1'b0, "R3", "idle after final beat", 32'(busy_o), 32'd0);
    chk(last_o == 1'b0, "R3", "last clear when idle", 32'(last_o), 32'd0);
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: run did not complete, actual=%0d cycles expected<150000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    int lens[8] = '{0, 1, 2, 3, 7, 15, 16, 255};
    int n;
    logic [31:0] st;
    checks = 0; errors = 0;
    rst_n = 1'b0; load_i = 1'b0; step_i = 1'b0;
    start_addr_i = '0; len_i = '0; size_i = '0; kind_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(busy_o == 1'b0, "R1", "busy in reset", 32'(busy_o), 32'd0);
    chk(last_o == 1'b0, "R1", "last in reset", 32'(last_o), 32'd0);
    chk(err_o == 1'b0, "R1", "err in reset", 32'(err_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0 && err_o == 1'b0, "R1", "idle after reset", 32'(busy_o), 32'd0);

    // R4: steps while idle are ignored
    step_i = 1'b1;
    repeat (4) @(negedge clk);
    step_i = 1'b0;
    chk(busy_o == 1'b0, "R4", "idle step ignored", 32'(busy_o), 32'd0);
    chk(last_o == 1'b0, "R4", "idle step no last", 32'(last_o), 32'd0);

    // sweep: every kind x every size x selected lengths
    n = 0;
    for (int k = 0; k < 4; k++) begin
      for (int s = 0; s < 8; s++) begin
        for (int li = 0; li < 8; li++) begin
          st = 32'h0004_0000 + ((n * 32'd173) & 32'h0000_0FFF);
          load_burst(st, 2'(k), s, lens[li], 1'b0);
          chk(addr_o == st, "R2", "start captured", addr_o, st);
          walk(st, 2'(k), s, lens[li], (n % 3) == 0, 0);
          n++;
        end
      end
    end

    // R10: a load with a simultaneous step restarts the burst
    load_burst(32'h0000_1000, 2'b01, 2, 7, 1'b0);
    step_i = 1'b1; @(negedge clk);
    step_i = 1'b1; @(negedge clk);
    step_i = 1'b0;
    chk(addr_o == 32'h0000_1008, "R6", "incr before restart", addr_o, 32'h0000_1008);
    load_burst(32'h0000_2034, 2'b10, 3, 3, 1'b1);
    chk(addr_o == 32'h0000_2034, "R10", "restart address", addr_o, 32'h0000_2034);
    chk(last_o == 1'b0, "R10", "restart last", 32'(last_o), 32'd0);
    walk(32'h0000_2034, 2'b10, 3, 3, 1'b0, 0);

    // R10: error recomputed on restart (reserved then clean)
    load_burst(32'h0000_3000, 2'b11, 0, 4, 1'b0);
    chk(err_o == 1'b1, "R9", "reserved raises err", 32'(err_o), 32'd1);
    load_burst(32'h0000_3100, 2'b00, 0, 1, 1'b0);
    chk(err_o == 1'b0, "R10", "err cleared by clean load", 32'(err_o), 32'd0);
    walk(32'h0000_3100, 2'b00, 0, 1, 1'b0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule